// File: doc/BRIEF.md
# Threshold wake-up interrupt generator

This block watches a stream of three-axis acceleration samples and raises an interrupt when an axis moves past a programmable threshold. Each time a sample-valid strobe arrives, every axis is tested against the threshold in both directions, which gives six events: high and low for X, Y and Z. A configuration byte picks which of these events count. It also selects whether the counted events are ORed together or must all hold at once, and whether the interrupt is held until software acknowledges it.

The result is kept in a source byte. The byte carries the enabled events that fired and an active bit, and the interrupt line follows the active bit. A one-cycle acknowledge strobe, which stands for a read of the acknowledge location, clears the source byte. The threshold arrives as a low byte and a high byte and is used as an unsigned magnitude. A high event needs the sample to be strictly above plus the threshold. A low event needs the sample to be strictly below minus the threshold.

Top module: `wkup_irq_gen`

## Requirements
- R1: After reset, `src` is 0x00 and `irq` is low.
- R2: Events are evaluated only in a cycle where `smp_vld` is high. With `smp_vld` and `ack` both low, `src` does not change, whatever the samples do.
- R3: The threshold T is {`thr_hi`,`thr_lo`}, read as unsigned. A high event fires when the signed sample is greater than +T. A low event fires when the signed sample is less than -T. A sample equal to either limit fires nothing.
- R4: Bit positions in `cfg` and `src` are: bit0 X low, bit1 X high, bit2 Y low, bit3 Y high, bit4 Z low, bit5 Z high. In `src`, bit6 is the active flag and bit7 is always 0. Only events whose `cfg` mask bit is 1 are recorded in `src`.
- R5: With `cfg[7]`=0 (any-mode), a sample is active when at least one enabled event fires.
- R6: With `cfg[7]`=1 (all-mode), a sample is active only when every enabled event fires on that same sample. The enabled events that did fire are still recorded.
- R7: When `cfg[5:0]` is 0, no sample is ever active, in either mode.
- R8: With `cfg[6]`=0, each evaluation replaces `src` completely, so `irq` drops at the first sample that is not active.
- R9: With `cfg[6]`=1 (hold), each evaluation ORs its flags into `src`. `irq` stays high until an acknowledge.
- R10: `ack` clears `src` to 0x00 at the next edge. When `ack` and `smp_vld` come in the same cycle, the cleared value is combined with the new evaluation.
- R11: `irq` equals `src[6]`. Both change at the clock edge that samples the `smp_vld` strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | New sample set is present |
| smp_xyz | input | 48 | Signed samples: X in [15:0], Y in [31:16], Z in [47:32] |
| cfg | input | 8 | bit7 all-mode, bit6 hold, bits5..0 event masks |
| thr_lo | input | 8 | Threshold low byte |
| thr_hi | input | 8 | Threshold high byte |
| ack | input | 1 | Acknowledge strobe; clears the source byte |
| src | output | 8 | Source byte: active flag and recorded events |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check several behaviours on every cycle. The source byte stays frozen when there is no strobe and no acknowledge. An acknowledge empties it. A held interrupt stays up until an acknowledge. A strobe without hold loads exactly the masked events. An any-mode hit always raises the line, and an empty mask never raises it in non-hold mode. Other behaviours can only be shown by the bench's scenarios against its reference model. These are the exact compare limits at ±T, including the extreme threshold and sample values, and the all-mode partial-match case. They also include the overlap of an acknowledge with a strobe and the one-edge latency of the line.

// File: rtl/wkup_pkg.sv
`timescale 1ns/1ps
package wkup_pkg;
  // Event index within the six-bit event vector: low event first, then high.
  function automatic int unsigned ev_index(input int unsigned axis, input bit high);
    return 2 * axis + (high ? 1 : 0);
  endfunction

  typedef enum logic {
    COMB_ANY = 1'b0,
    COMB_ALL = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/wkup_axis_cmp.sv
`timescale 1ns/1ps
module wkup_axis_cmp #(
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 16
) (
  input  logic signed [DW-1:0] sample,
  input  logic        [TW-1:0] thr,
  output logic                 ev_hi,
  output logic                 ev_lo
);
  localparam int unsigned EW = ((DW > TW) ? DW : TW) + 2;

  // Widen both operands so that -T never wraps.
  function automatic logic signed [EW-1:0] widen_smp(input logic signed [DW-1:0] s);
    return EW'(s);
  endfunction

  function automatic logic signed [EW-1:0] widen_thr(input logic [TW-1:0] t);
    return $signed({{(EW-TW){1'b0}}, t});
  endfunction

  function automatic logic above_pos(input logic signed [DW-1:0] s, input logic [TW-1:0] t);
    return widen_smp(s) > widen_thr(t);
  endfunction

  function automatic logic below_neg(input logic signed [DW-1:0] s, input logic [TW-1:0] t);
    return widen_smp(s) < -widen_thr(t);
  endfunction

  assign ev_hi = above_pos(sample, thr);
  assign ev_lo = below_neg(sample, thr);
endmodule

// File: rtl/wkup_combine.sv
`timescale 1ns/1ps
module wkup_combine #(
  parameter int unsigned NAX = 3,
  localparam int unsigned NEV = 2 * NAX
) (
  input  logic [NEV-1:0]   ev,
  input  logic [NEV-1:0]   mask,
  input  wkup_pkg::comb_mode_e mode,
  output logic [NEV-1:0]   kept,
  output logic             hit
);
  function automatic logic combine(input logic [NEV-1:0] k, input logic [NEV-1:0] m,
                                   input wkup_pkg::comb_mode_e md);
    if (m == '0) return 1'b0;
    if (md == wkup_pkg::COMB_ALL) return (k == m);
    return |k;
  endfunction

  assign kept = ev & mask;
  assign hit  = combine(kept, mask, mode);
endmodule

// File: rtl/wkup_src_reg.sv
`timescale 1ns/1ps
module wkup_src_reg #(
  parameter int unsigned NEV = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vld,
  input  logic           ack,
  input  logic           hold,
  input  logic [NEV-1:0] kept,
  input  logic           hit,
  output logic [NEV:0]   src_q
);
  logic [NEV:0] fresh;
  logic [NEV:0] base;
  logic [NEV:0] src_d;

  assign fresh = {hit, kept};
  assign base  = ack ? '0 : src_q;

  always_comb begin
    src_d = base;
    if (vld) src_d = hold ? (base | fresh) : fresh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !vld) |=> (src_q == '0)); // R10
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld && !ack) |=> $stable(src_q)); // R2
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ack && src_q[NEV]) |=> src_q[NEV]); // R9
  AST_PLAIN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !hold) |=> (src_q[NEV-1:0] == $past(kept))); // R8
endmodule

// File: rtl/wkup_irq_gen.sv
`timescale 1ns/1ps
module wkup_irq_gen #(
  parameter int unsigned DW  = 16,
  parameter int unsigned NAX = 3,
  parameter int unsigned TW  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic [NAX*DW-1:0]    smp_xyz,
  input  logic [2*NAX+1:0]     cfg,
  input  logic [TW/2-1:0]      thr_lo,
  input  logic [TW-TW/2-1:0]   thr_hi,
  input  logic                 ack,
  output logic [2*NAX+1:0]     src,
  output logic                 irq
);
  localparam int unsigned NEV    = 2 * NAX;
  localparam int unsigned HOLD_B = NEV;
  localparam int unsigned MODE_B = NEV + 1;

  logic [TW-1:0]  thr;
  logic [NEV-1:0] ev_raw;
  logic [NEV-1:0] ev_mask;
  logic [NEV-1:0] ev_kept;
  logic           ev_hit;
  logic           hold_en;
  wkup_pkg::comb_mode_e comb_mode;
  logic [NEV:0]   src_q;

  assign thr       = {thr_hi, thr_lo};
  assign ev_mask   = cfg[NEV-1:0];
  assign hold_en   = cfg[HOLD_B];
  assign comb_mode = wkup_pkg::comb_mode_e'(cfg[MODE_B]);

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    wkup_axis_cmp #(.DW(DW), .TW(TW)) u_cmp (
      .sample (smp_xyz[a*DW +: DW]),
      .thr    (thr),
      .ev_hi  (ev_raw[wkup_pkg::ev_index(a, 1'b1)]),
      .ev_lo  (ev_raw[wkup_pkg::ev_index(a, 1'b0)])
    );
  end

  wkup_combine #(.NAX(NAX)) u_comb (
    .ev   (ev_raw),
    .mask (ev_mask),
    .mode (comb_mode),
    .kept (ev_kept),
    .hit  (ev_hit)
  );

  wkup_src_reg #(.NEV(NEV)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .vld   (smp_vld),
    .ack   (ack),
    .hold  (hold_en),
    .kept  (ev_kept),
    .hit   (ev_hit),
    .src_q (src_q)
  );

  assign src = {1'b0, src_q};
  assign irq = src_q[NEV];

  AST_EMPTY_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !hold_en && (ev_mask == '0)) |=> !irq); // R7
  AST_ANY_MODE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (comb_mode == wkup_pkg::COMB_ANY) && ((ev_raw & ev_mask) != '0)) |=> irq); // R5
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !src[2*NAX+1]); // R4
endmodule

// File: tb/wkup_irq_gen_bench.sv
`timescale 1ns/1ps
module wkup_irq_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [47:0] smp_xyz = '0;
  logic [7:0]  cfg = '0;
  logic [7:0]  thr_lo = '0;
  logic [7:0]  thr_hi = '0;
  logic        ack = 1'b0;
  logic [7:0]  src;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int m_src = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wkup_irq_gen u_wkup_irq_gen (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_xyz(smp_xyz),
    .cfg(cfg), .thr_lo(thr_lo), .thr_hi(thr_hi), .ack(ack),
    .src(src), .irq(irq)
  );

  // Behavioural reference: integers only.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_src = 0;
    else begin
      int t, ev, msk, kept, nw, hit;
      t = {thr_hi, thr_lo};
      ev = 0;
      for (int a = 0; a < 3; a++) begin
        int v;
        v = $signed(smp_xyz[a*16 +: 16]);
        if (v > t)  ev = ev | (1 << (2*a + 1));
        if (v < -t) ev = ev | (1 << (2*a));
      end
      msk  = cfg & 8'h3F;
      kept = ev & msk;
      if (msk == 0) hit = 0;
      else if (cfg[7]) hit = (kept == msk) ? 1 : 0;
      else hit = (kept != 0) ? 1 : 0;
      nw = kept | (hit << 6);
      if (smp_vld) m_src = cfg[6] ? ((ack ? 0 : m_src) | nw) : nw;
      else if (ack) m_src = 0;
    end
  end

  // Compare against the model on every clock.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      n_chk++;
      if (src !== m_src[7:0] || irq !== m_src[6]) begin
        n_bad++;
        $display("FAIL R4 R11 model compare: src=%02h irq=%0b expected src=%02h irq=%0b",
                 src, irq, m_src[7:0], m_src[6]);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic step(input bit v, input bit a, input int x, input int y, input int z);
    @(negedge clk);
    smp_vld = v;
    ack = a;
    smp_xyz = {16'(z), 16'(y), 16'(x)};
    @(posedge clk);
    #1;
  endtask

  task automatic set_thr(input int t);
    thr_lo = t[7:0];
    thr_hi = t[15:8];
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset src", src, 8'h00);
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 / R5: high limit, any-mode, X high enabled
    set_thr(256);
    cfg = 8'h02;
    step(1, 0, 257, 0, 0);  check("R3 above +T", src, 8'h42);
    step(1, 0, 256, 0, 0);  check("R3 equal +T / R8 drop", src, 8'h00);
    cfg = 8'h01;
    step(1, 0, -257, 0, 0); check("R3 below -T", src, 8'h41);
    step(1, 0, -256, 0, 0); check("R3 equal -T", src, 8'h00);

    // R11: no change before the edge
    cfg = 8'h02;
    @(negedge clk);
    smp_vld = 1; ack = 0; smp_xyz = {16'd0, 16'd0, 16'd300};
    #1;
    check("R11 before edge", {7'd0, irq}, 8'h00);
    @(posedge clk); #1;
    check("R11 at edge", {7'd0, irq}, 8'h01);

    // R2: samples ignored without strobe
    step(0, 0, 0, 0, 0);
    step(0, 0, -5000, 5000, 5000);
    check("R2 no strobe", src, 8'h42);
    step(0, 1, 0, 0, 0);    check("R10 ack clears", src, 8'h00);

    // R4: masking and bit positions
    cfg = 8'h02;
    step(1, 0, 0, 1000, -1000); check("R4 masked off", src, 8'h00);
    cfg = 8'h3F;
    step(1, 0, 0, 1000, -1000); check("R4 YH ZL positions", src, 8'h58);
    step(1, 0, -1000, 0, 1000); check("R4 XL ZH positions", src, 8'h61);

    // R6: all-mode
    cfg = 8'h8A;
    step(1, 0, 500, 0, 0);   check("R6 partial", src, 8'h02);
    step(1, 0, 500, 500, 0); check("R6 full", src, 8'h4A);

    // R7: empty mask
    cfg = 8'h80;
    step(1, 0, 9000, 9000, 9000);  check("R7 all-mode empty", src, 8'h00);
    cfg = 8'h00;
    step(1, 0, -9000, 9000, 9000); check("R7 any-mode empty", src, 8'h00);

    // R9 / R10: hold
    cfg = 8'h43;
    step(1, 0, 500, 0, 0);  check("R9 set", src, 8'h42);
    step(1, 0, 0, 0, 0);    check("R9 kept", src, 8'h42);
    step(1, 0, -500, 0, 0); check("R9 accumulate", src, 8'h43);
    step(1, 1, 500, 0, 0);  check("R10 ack with strobe", src, 8'h42);
    step(0, 1, 0, 0, 0);    check("R10 ack hold", src, 8'h00);

    // R3 extremes
    set_thr(16'h7FFF);
    cfg = 8'h01;
    step(1, 0, -32768, 0, 0); check("R3 min vs 7FFF", src, 8'h41);
    set_thr(16'hFFFF);
    step(1, 0, -32768, 0, 0); check("R3 min vs FFFF", src, 8'h00);
    cfg = 8'h02;
    step(1, 0, 32767, 0, 0);  check("R3 max vs FFFF", src, 8'h00);
    set_thr(0);
    step(1, 0, 1, 0, 0);      check("R3 zero threshold", src, 8'h42);
    step(0, 0, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule